// File: doc/BRIEF.md
# Vector Byte Permute and Align Unit

This unit rearranges the bytes of two 128-bit operands, `A` and `B`. Each operand holds sixteen bytes, with byte 0 in the least significant bits. A one-bit opcode picks one of two functions. In permute mode, each byte of `B` is a control byte that chooses one byte of `A` for the matching output position, or forces that position to zero. In align mode, the two operands are joined into a 32-byte value and shifted right by a whole number of bytes given by an 8-bit immediate.

Operands enter on a valid/ready stream, and results leave on a second valid/ready stream. An input beat is taken on any rising edge where `in_valid` and `in_ready` are both high. An output beat is delivered on any edge where `out_valid` and `out_ready` are both high. With the default registered output, the unit holds at most one result. `in_ready` is high whenever that result slot is empty or is being drained in the same cycle. A result that is not taken stays on `out_data` unchanged, and `out_valid` stays high, until the consumer takes it. Setting `OUT_REG` to 0 removes the register: results then appear in the same cycle, and ready passes straight from the output side to the input side.

Top module: `vbyte_perm_unit`

## Requirements
- R1: With `in_op` = 0 (permute), output byte i equals byte k of `in_a`, where k is bits 3:0 of control byte i of `in_b`, provided bit 7 of that control byte is clear.
- R2: In permute mode, output byte i is 0x00 whenever bit 7 of control byte i is set, whatever the other bits hold.
- R3: In permute mode, bits 6:4 of a control byte have no effect. Setting any of them in a control byte whose bit 7 is clear leaves the result unchanged.
- R4: With `in_op` = 1 (align), the result is the low 16 bytes of the 32-byte value {`in_a`, `in_b`} (with `in_b` in the low half) shifted right by `in_imm` bytes.
- R5: In align mode, a shift of 0 returns `in_b` unchanged, and a shift of 16 returns `in_a` unchanged.
- R6: In align mode, for a shift n with 16 < n ≤ 32, the result is `in_a` shifted right by n−16 bytes with zero bytes filling the top. A shift of 32 gives all zeros.
- R7: In align mode, any shift from 33 to 255 gives all zeros.
- R8: With the registered output, the result of a beat accepted at edge t appears on `out_data`, with `out_valid` high, from edge t onward. `out_valid` is high exactly when an accepted result has not yet been delivered.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero on the next edge, and any pending result is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can accept an input beat |
| in_op | input | 1 | 0 = permute, 1 = align |
| in_imm | input | 8 | Align shift in bytes (unsigned) |
| in_a | input | 128 | Operand A (source bytes / upper half) |
| in_b | input | 128 | Operand B (control bytes / lower half) |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 128 | Result bytes |

## Verification
Permute mode is tried with three kinds of control vector. Mixed indices show whether the low nibble really selects the source byte. Vectors with the top bit set in various positions separate zeroing from selection. The same indices with bits 6:4 raised would expose a decoder that uses more than four index bits. Align mode is swept over the shifts 0, 1, 15, 16, 17, 31, 32, 33, 200 and 255. These show the boundary between the two halves, the zero-fill of the top bytes, and the all-zero region. Operand A and operand B carry distinct byte values, so any swap of the halves is visible. All of this runs while `out_ready` is toggled pseudo-randomly and at times held low, which checks that stalled results hold and are never lost or duplicated.

// File: rtl/vbyte_perm_pkg.sv
package vbyte_perm_pkg;
  typedef enum logic {
    OP_PERMUTE = 1'b0,
    OP_ALIGN   = 1'b1
  } vbp_op_e;
endpackage

// File: rtl/vbyte_permute.sv
module vbyte_permute #(
  parameter int NBYTES = 16,
  parameter int BYTE_W = 8
) (
  input  logic [NBYTES*BYTE_W-1:0] src,
  input  logic [NBYTES*BYTE_W-1:0] ctrl,
  output logic [NBYTES*BYTE_W-1:0] dst
);
  localparam int IDXW = $clog2(NBYTES);

  logic [BYTE_W-1:0] src_byte [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_unpack
    assign src_byte[g] = src[g*BYTE_W +: BYTE_W];
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] cb;
    logic [IDXW-1:0]   sel;
    logic              kill;
    assign cb   = ctrl[g*BYTE_W +: BYTE_W];
    assign sel  = cb[IDXW-1:0];
    assign kill = cb[BYTE_W-1];
    assign dst[g*BYTE_W +: BYTE_W] = kill ? '0 : src_byte[sel];
  end
endmodule

// File: rtl/vbyte_align.sv
module vbyte_align #(
  parameter int NBYTES = 16,
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 8
) (
  input  logic [NBYTES*BYTE_W-1:0] hi,
  input  logic [NBYTES*BYTE_W-1:0] lo,
  input  logic [IMM_W-1:0]         shift,
  output logic [NBYTES*BYTE_W-1:0] dst
);
  localparam int IDXW = $clog2(NBYTES);
  localparam int SW   = ((IMM_W > IDXW) ? IMM_W : IDXW) + 2;

  logic [BYTE_W-1:0] hi_byte [NBYTES];
  logic [BYTE_W-1:0] lo_byte [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_unpack
    assign hi_byte[g] = hi[g*BYTE_W +: BYTE_W];
    assign lo_byte[g] = lo[g*BYTE_W +: BYTE_W];
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [SW-1:0] pos;
    logic [SW-1:0] pos_hi;
    assign pos    = SW'(shift) + SW'(g);
    assign pos_hi = pos - SW'(NBYTES);
    always_comb begin
      if (pos < SW'(NBYTES))
        dst[g*BYTE_W +: BYTE_W] = lo_byte[pos[IDXW-1:0]];
      else if (pos < SW'(2*NBYTES))
        dst[g*BYTE_W +: BYTE_W] = hi_byte[pos_hi[IDXW-1:0]];
      else
        dst[g*BYTE_W +: BYTE_W] = '0;
    end
  end
endmodule

// File: rtl/vbyte_out_stage.sv
module vbyte_out_stage #(
  parameter int W       = 128,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  output logic         d_ready,
  input  logic [W-1:0] d_data,
  output logic         q_valid,
  input  logic         q_ready,
  output logic [W-1:0] q_data
);
  if (OUT_REG) begin : g_reg
    logic         vld_r;
    logic [W-1:0] dat_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_r <= 1'b0;
        dat_r <= '0;
      end else if (d_ready) begin
        vld_r <= d_valid;
        if (d_valid) dat_r <= d_data;
      end
    end

    assign d_ready = !vld_r || q_ready;
    assign q_valid = vld_r;
    assign q_data  = dat_r;

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
      (q_valid && !q_ready) |=> (q_valid && $stable(q_data)));

    a_r8_accept_shows: assert property (@(posedge clk) disable iff (rst)
      (d_valid && d_ready) |=> (q_valid && q_data == $past(d_data)));

    a_r9_drain_empties: assert property (@(posedge clk) disable iff (rst)
      (q_valid && q_ready && !d_valid) |=> !q_valid);
  end else begin : g_pass
    assign d_ready = q_ready;
    assign q_valid = d_valid;
    assign q_data  = d_data;
  end
endmodule

// File: rtl/vbyte_perm_unit.sv
module vbyte_perm_unit
  import vbyte_perm_pkg::*;
#(
  parameter int NBYTES  = 16,
  parameter int BYTE_W  = 8,
  parameter int IMM_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_op,
  input  logic [IMM_W-1:0]         in_imm,
  input  logic [NBYTES*BYTE_W-1:0] in_a,
  input  logic [NBYTES*BYTE_W-1:0] in_b,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NBYTES*BYTE_W-1:0] out_data
);
  localparam int VW = NBYTES * BYTE_W;

  logic [VW-1:0] perm_res;
  logic [VW-1:0] align_res;
  logic [VW-1:0] result;
  vbp_op_e       op;

  assign op = vbp_op_e'(in_op);

  vbyte_permute #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_perm (
    .src (in_a),
    .ctrl(in_b),
    .dst (perm_res)
  );

  vbyte_align #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .IMM_W(IMM_W)) u_align (
    .hi   (in_a),
    .lo   (in_b),
    .shift(in_imm),
    .dst  (align_res)
  );

  assign result = (op == OP_ALIGN) ? align_res : perm_res;

  vbyte_out_stage #(.W(VW), .OUT_REG(OUT_REG)) u_out (
    .clk    (clk),
    .rst    (rst),
    .d_valid(in_valid),
    .d_ready(in_ready),
    .d_data (result),
    .q_valid(out_valid),
    .q_ready(out_ready),
    .q_data (out_data)
  );

  if (OUT_REG) begin : g_chk
    a_r2_lane0_zero: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_op == 1'b0 && in_b[BYTE_W-1])
      |=> (out_data[BYTE_W-1:0] == '0));

    a_r7_far_shift_zero: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_op == 1'b1 && int'(in_imm) > 2*NBYTES)
      |=> (out_data == '0));

    a_r5_zero_shift_is_b: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_op == 1'b1 && in_imm == '0)
      |=> (out_data == $past(in_b)));

    a_r5_full_shift_is_a: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_op == 1'b1 && int'(in_imm) == NBYTES)
      |=> (out_data == $past(in_a)));
  end
endmodule

// File: tb/sim_vbyte_perm_unit.sv
module sim_vbyte_perm_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_op = 1'b0;
  logic [7:0]   in_imm = '0;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;        // 0 pseudo-random, 1 always ready, 2 never ready
  logic [15:0] lfsr = 16'hACE1;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbyte_perm_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_imm(in_imm), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b,
                                         logic op, logic [7:0] imm);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      if (!op) begin
        logic [7:0] c = b[i*8 +: 8];
        if (!c[7]) r[i*8 +: 8] = a[int'(c[3:0])*8 +: 8];
      end else begin
        int s = int'(imm) + i;
        if (s < 16)      r[i*8 +: 8] = b[s*8 +: 8];
        else if (s < 32) r[i*8 +: 8] = a[(s-16)*8 +: 8];
      end
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: settle inputs, record handshakes, advance, update model, compare
  task automatic step(output bit took);
    bit fin, fout;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : (lfsr[0] | lfsr[3]);
    #1;
    check(in_ready == (!out_valid || out_ready), "R9", "in_ready",
          128'(in_ready), 128'(!out_valid || out_ready));
    fin  = in_valid && in_ready && !rst;
    fout = out_valid && out_ready && !rst;
    @(posedge clk);
    if (rst) begin
      exp_q.delete();
      tag_q.delete();
    end else begin
      if (fout) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
      if (fin) begin
        exp_q.push_back(model(in_a, in_b, in_op, in_imm));
        tag_q.push_back(cur_tag);
      end
    end
    took = fin;
    @(negedge clk);
    check(out_valid == (exp_q.size() != 0), "R8", "out_valid",
          128'(out_valid), 128'(exp_q.size() != 0));
    if (out_valid && exp_q.size() != 0)
      check(out_data === exp_q[0], tag_q[0], "out_data", out_data, exp_q[0]);
  endtask

  string cur_tag = "R1";

  task automatic send(logic [127:0] a, logic [127:0] b, logic op, logic [7:0] imm, string tag);
    bit took = 1'b0;
    in_a = a; in_b = b; in_op = op; in_imm = imm; cur_tag = tag;
    in_valid = 1'b1;
    while (!took) step(took);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    bit t;
    for (int k = 0; k < n; k++) step(t);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] va, vb, vc;
    bit t;
    for (int i = 0; i < 16; i++) va[i*8 +: 8] = 8'hA0 + 8'(i);
    for (int i = 0; i < 16; i++) vb[i*8 +: 8] = 8'h30 + 8'(i*3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0 && out_data == '0, "R10", "reset state",
          out_data, '0);
    rst = 1'b0;

    // R1: index selection
    for (int i = 0; i < 16; i++) vc[i*8 +: 8] = 8'((15 - i) ^ (i * 5 % 16));
    send(va, vc, 1'b0, 8'h00, "R1");
    for (int i = 0; i < 16; i++) vc[i*8 +: 8] = 8'(i % 4);
    send(va, vc, 1'b0, 8'h77, "R1");
    // R2: top bit zeroes lane
    for (int i = 0; i < 16; i++) vc[i*8 +: 8] = (i % 3 == 0) ? 8'h80 | 8'(i) : 8'(i);
    send(va, vc, 1'b0, 8'h00, "R2");
    send(va, {16{8'hFF}}, 1'b0, 8'h00, "R2");
    // R3: bits 6:4 ignored
    for (int i = 0; i < 16; i++) vc[i*8 +: 8] = 8'(i * 7 % 16) | 8'h70;
    send(va, vc, 1'b0, 8'h00, "R3");
    for (int i = 0; i < 16; i++) vc[i*8 +: 8] = 8'(i * 7 % 16) | 8'h20;
    send(va, vc, 1'b0, 8'h00, "R3");

    // align sweep
    send(va, vb, 1'b1, 8'd0,   "R5");
    send(va, vb, 1'b1, 8'd16,  "R5");
    send(va, vb, 1'b1, 8'd1,   "R4");
    send(va, vb, 1'b1, 8'd15,  "R4");
    send(va, vb, 1'b1, 8'd17,  "R6");
    send(va, vb, 1'b1, 8'd31,  "R6");
    send(va, vb, 1'b1, 8'd32,  "R6");
    send(va, vb, 1'b1, 8'd33,  "R7");
    send(va, vb, 1'b1, 8'd200, "R7");
    send(va, vb, 1'b1, 8'd255, "R7");
    idle(4);

    // R9: stall holds result, then drains
    rdy_mode = 2;
    send(vb, va, 1'b1, 8'd5, "R9");
    idle(5);
    rdy_mode = 1;
    idle(2);

    // back-to-back with full throughput (R8)
    send(va, vb, 1'b0, 8'h00, "R8");
    send(vb, va, 1'b1, 8'd9,  "R8");
    rdy_mode = 0;

    // pseudo-random mix
    for (int n = 0; n < 60; n++) begin
      logic [127:0] ra, rb;
      for (int w = 0; w < 4; w++) begin
        ra[w*32 +: 32] = $urandom();
        rb[w*32 +: 32] = $urandom();
      end
      send(ra, rb, n[0], 8'($urandom_range(0, 40)), n[0] ? "R4" : "R1");
    end
    idle(6);

    // R10: reset drops a pending result
    rdy_mode = 2;
    send(va, vb, 1'b1, 8'd3, "R10");
    rst = 1'b1;
    step(t);
    rst = 1'b0;
    check(out_valid == 1'b0 && out_data == '0, "R10", "mid-run reset",
          out_data, '0);
    rdy_mode = 1;
    idle(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule